// File: doc/BRIEF.md
# Register Pointer Auto-Increment Unit

This block sits behind a serial-bus slave's address matcher. It keeps the command byte that the bus controller writes straight after a successful address match. The command byte carries a 6-bit register pointer and an increment-enable flag. The pointer addresses the register file for every data byte that follows in the same transaction.

Each time a data byte has been transferred, read or write alike, the bus controller pulses a done strobe. The unit then either leaves the pointer where it is or advances it. Advancing follows one of four wrap windows, chosen by a 2-bit mode taken from a separate mode register. Each window has a fixed upper limit and restart value, so a host can sweep all registers, only the per-channel brightness registers, only the global group, or brightness plus global, in one burst.

The register file and the bit-level bus engine are outside this block.

Top module: `regptr_autoinc`

## Requirements
- R1: A command write loads the pointer from bits 5:0 and the flag from bit 7 of the command byte; bit 6 is ignored and changes neither output.
- R2: After reset the pointer is 00h and the flag is 1 (the command byte reads as 80h).
- R3: With the flag at 0, a done strobe leaves the pointer unchanged for every mode value (00, 01, 10, 11).
- R4: With the flag at 1 and mode 00, a done strobe adds one to the pointer, and the pointer goes from 26h to 00h.
- R5: With the flag at 1 and mode 01, a done strobe adds one, and the pointer goes from 19h to 02h.
- R6: With the flag at 1 and mode 10, a done strobe adds one, and the pointer goes from 1Ch to 1Ah.
- R7: With the flag at 1 and mode 11, a done strobe adds one, and the pointer goes from 1Ch to 02h.
- R8: A pointer that is not equal to the active window's upper limit always advances by one, including values outside the window, and 3Fh advances to 00h.
- R9: When a command write and a done strobe arrive in the same cycle, the command write wins and no increment is applied.
- R10: Without a command write or a done strobe, pointer and flag hold, even when the mode input changes.
- R11: The mode is sampled at each done strobe, so a mode change part-way through a burst takes effect on the next increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte: bit 7 increment flag, bit 6 unused, bits 5:0 pointer |
| xfer_done | input | 1 | One data byte has been read or written |
| inc_mode | input | 2 | Window select from the mode register |
| reg_ptr | output | 6 | Current register pointer |
| inc_flag | output | 1 | Stored increment flag |

## Verification
The bench builds the unit with its default 6-bit pointer and 2-bit mode. At that size every pointer value from 00h to 3Fh can be combined with every flag and mode pairing, and one increment can be checked for each of the 512 combinations. This covers every in-window step, every wrap point, and every start point outside a window. Full-window walks in each mode, a mid-burst mode change and a collision of command write with done strobe exercise the sequencing on top of the sweep.

// File: rtl/regptr_pkg.sv
package regptr_pkg;

    localparam int PTR_W  = 6;
    localparam int MODE_W = 2;
    localparam int N_WIN  = 1 << MODE_W;
    localparam int CMD_W  = PTR_W + 2;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [MODE_W-1:0] mode_t;

    typedef struct packed {
        logic aif;
        logic spare;
        ptr_t ptr;
    } cmd_byte_t;

    typedef struct packed {
        ptr_t lo;
        ptr_t hi;
    } win_t;

    localparam cmd_byte_t CMD_RESET = '{aif: 1'b1, spare: 1'b0, ptr: '0};

    // Window limits, one entry per mode value
    function automatic win_t win_of(input int idx);
        win_t w;
        case (idx)
            0:       begin w.lo = ptr_t'(8'h00); w.hi = ptr_t'(8'h26); end
            1:       begin w.lo = ptr_t'(8'h02); w.hi = ptr_t'(8'h19); end
            2:       begin w.lo = ptr_t'(8'h1A); w.hi = ptr_t'(8'h1C); end
            default: begin w.lo = ptr_t'(8'h02); w.hi = ptr_t'(8'h1C); end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/regptr_win_sel.sv
module regptr_win_sel
    import regptr_pkg::*;
(
    input  mode_t mode,
    output win_t  win
);
    win_t table_q [N_WIN];

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        assign table_q[g] = win_of(g);
    end

    assign win = table_q[mode];
endmodule

// File: rtl/regptr_step.sv
module regptr_step
    import regptr_pkg::*;
(
    input  ptr_t cur,
    input  logic flag,
    input  win_t win,
    output ptr_t nxt
);
    always_comb begin
        if (!flag)
            nxt = cur;
        else if (cur == win.hi)
            nxt = win.lo;
        else
            nxt = cur + ptr_t'(1);
    end
endmodule

// File: rtl/regptr_cmd_reg.sv
module regptr_cmd_reg
    import regptr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  cmd_byte_t load_val,
    input  logic      adv,
    input  ptr_t      adv_ptr,
    output cmd_byte_t state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CMD_RESET;
        end else if (load) begin
            state.aif   <= load_val.aif;
            state.spare <= 1'b0;
            state.ptr   <= load_val.ptr;
        end else if (adv) begin
            state.ptr <= adv_ptr;
        end
    end
endmodule

// File: rtl/regptr_autoinc.sv
module regptr_autoinc
    import regptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_byte,
    input  logic             xfer_done,
    input  logic [MODE_W-1:0] inc_mode,
    output logic [PTR_W-1:0] reg_ptr,
    output logic             inc_flag
);
    cmd_byte_t cur_q;
    win_t      win_w;
    ptr_t      nxt_w;

    regptr_win_sel u_win (
        .mode (mode_t'(inc_mode)),
        .win  (win_w)
    );

    regptr_step u_step (
        .cur  (cur_q.ptr),
        .flag (cur_q.aif),
        .win  (win_w),
        .nxt  (nxt_w)
    );

    regptr_cmd_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd_wr),
        .load_val (cmd_byte_t'(cmd_byte)),
        .adv      (xfer_done),
        .adv_ptr  (nxt_w),
        .state    (cur_q)
    );

    assign reg_ptr  = cur_q.ptr;
    assign inc_flag = cur_q.aif;
endmodule

// File: rtl/regptr_autoinc_chk.sv
module regptr_autoinc_chk
    import regptr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmd_wr,
    input logic [CMD_W-1:0] cmd_byte,
    input logic             xfer_done,
    input logic [MODE_W-1:0] inc_mode,
    input logic [PTR_W-1:0] reg_ptr,
    input logic             inc_flag
);
    AST_CMD_LOAD: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> (reg_ptr == $past(cmd_byte[PTR_W-1:0]) && inc_flag == $past(cmd_byte[CMD_W-1]))); // R1

    AST_FLAG_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd_wr && xfer_done && !inc_flag) |=> $stable(reg_ptr)); // R3

    AST_STEP_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (!cmd_wr && xfer_done && inc_flag) |=>
            (reg_ptr == ptr_t'($past(reg_ptr) + ptr_t'(1)) || reg_ptr < $past(reg_ptr))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd_wr && !xfer_done) |=> ($stable(reg_ptr) && $stable(inc_flag))); // R10

    AST_FLAG_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> $stable(inc_flag)); // R9
endmodule

bind regptr_autoinc regptr_autoinc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_byte  (cmd_byte),
    .xfer_done (xfer_done),
    .inc_mode  (inc_mode),
    .reg_ptr   (reg_ptr),
    .inc_flag  (inc_flag)
);

// File: tb/regptr_autoinc_bench.sv
module regptr_autoinc_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       xfer_done = 1'b0;
    logic [1:0] inc_mode = 2'b00;
    logic [5:0] reg_ptr;
    logic       inc_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    regptr_autoinc u_regptr_autoinc (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd_byte  (cmd_byte),
        .xfer_done (xfer_done),
        .inc_mode  (inc_mode),
        .reg_ptr   (reg_ptr),
        .inc_flag  (inc_flag)
    );

    function automatic int win_hi(input int m);
        case (m) 0: return 'h26; 1: return 'h19; default: return 'h1C; endcase
    endfunction

    function automatic int win_lo(input int m);
        case (m) 0: return 'h00; 2: return 'h1A; default: return 'h02; endcase
    endfunction

    function automatic int model_next(input int p, input int f, input int m);
        if (f == 0) return p;
        if (p == win_hi(m)) return win_lo(m);
        return (p + 1) % 64;
    endfunction

    function automatic string tag_of(input int p, input int f, input int m);
        if (f == 0) return "R3";
        if (p != win_hi(m)) return "R8";
        case (m) 0: return "R4"; 1: return "R5"; 2: return "R6"; default: return "R7"; endcase
    endfunction

    task automatic check(input string req, input int exp_p, input int exp_f);
        checks++;
        if (reg_ptr !== 6'(exp_p) || inc_flag !== 1'(exp_f)) begin
            errors++;
            $display("FAIL %s ptr=%02h flag=%0d expected ptr=%02h flag=%0d",
                     req, reg_ptr, inc_flag, exp_p, exp_f);
        end
    endtask

    task automatic write_cmd(input logic [7:0] b);
        @(negedge clk); cmd_wr = 1'b1; cmd_byte = b;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    initial begin
        int p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2", 'h00, 1);

        // bit 6 ignored
        write_cmd(8'hC5); check("R1", 'h05, 1);
        write_cmd(8'h45); check("R1", 'h05, 0);
        write_cmd(8'h7F); check("R1", 'h3F, 0);

        // exhaustive single-step sweep
        for (int f = 0; f < 2; f++)
            for (int m = 0; m < 4; m++)
                for (int s = 0; s < 64; s++) begin
                    inc_mode = 2'(m);
                    write_cmd({1'(f), 1'b0, 6'(s)});
                    check("R1", s, f);
                    pulse_done();
                    check(tag_of(s, f, m), model_next(s, f, m), f);
                end

        // full walks in each mode from 00h
        for (int m = 0; m < 4; m++) begin
            inc_mode = 2'(m);
            write_cmd(8'h80);
            p = 0;
            for (int k = 0; k < 70; k++) begin
                pulse_done();
                p = model_next(p, 1, m);
                check(tag_of(p, 1, m) == "R8" ? "R8" : "R4", p, 1);
            end
        end

        // command write beats done strobe
        inc_mode = 2'b00;
        write_cmd(8'h90);
        @(negedge clk); cmd_wr = 1'b1; cmd_byte = 8'h8A; xfer_done = 1'b1;
        @(negedge clk); cmd_wr = 1'b0; xfer_done = 1'b0;
        check("R9", 'h0A, 1);

        // idle with mode toggling
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); inc_mode = 2'(k);
        end
        @(negedge clk);
        check("R10", 'h0A, 1);

        // mode changed mid-burst
        write_cmd(8'h98); inc_mode = 2'b01;
        pulse_done(); check("R11", 'h19, 1);
        inc_mode = 2'b00;
        pulse_done(); check("R11", 'h1A, 1);
        inc_mode = 2'b10;
        pulse_done(); check("R11", 'h1B, 1);
        pulse_done(); check("R11", 'h1C, 1);
        pulse_done(); check("R6", 'h1A, 1);
        inc_mode = 2'b01;
        write_cmd(8'h99);
        pulse_done(); check("R5", 'h02, 1);

        // reset in the middle of a burst
        write_cmd(8'h33);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R2", 'h00, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog ptr=%02h flag=%0d expected completion", reg_ptr, inc_flag);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule